// File: doc/BRIEF.md
# Programmable clock divider with output inversion

This block derives a slower clock from an incoming clock by an integer ratio between 1 and 32. A single 8-bit configuration byte controls it. Bit 0 enables the divider. Bits 5 to 1 hold the ratio minus one. Bit 6 inverts the final output. Bit 7 is reserved and has no effect.

When the divider is enabled with a non-zero ratio code, a counter steps on every rising edge of the input clock. A register then produces the divided clock, which is high for the first half of each period. When the ratio is odd, the high half is the longer one. When the divider is disabled, or the code is zero, the input clock goes straight to the output. The inversion control acts in both cases. Whenever the ratio code or the enable bit changes, the counter starts a new period from its first high phase.

Top module: `clkdiv_top`

## Requirements
- R1: The configuration byte is decoded as follows: bit 0 is the enable, bits 5..1 are the ratio code c, bit 6 is the output invert, and bit 7 is ignored.
- R2: With enable=1 and c>0, the output period is exactly c+1 input clock cycles.
- R3: For even N=c+1, the divided clock is high for N/2 input cycles and low for N/2 input cycles.
- R4: For odd N=c+1 (N>=3), the divided clock is high for (N+1)/2 input cycles and low for (N-1)/2 input cycles.
- R5: With enable=1 and c=0, clk_o follows clk_i, XORed with the invert bit.
- R6: With enable=0, clk_o follows clk_i, XORed with the invert bit, whatever the ratio code.
- R7: With invert=1, clk_o is the complement of the output that the same configuration gives with invert=0.
- R8: The first rising clk_i edge after a change of the ratio code or the enable restarts the period. The divided clock (before inversion) is then high for the following input cycle.
- R9: While rst_ni is low, the divided clock before inversion is low. With the divider active, clk_o then equals the invert bit.
- R10: Toggling bit 7 alone does not restart or disturb the running period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Incoming clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Configuration byte: enable, ratio code, invert, reserved |
| clk_o | output | 1 | Divided (or forwarded) clock after optional inversion |

## Verification
Two functions can fall on the same rising edge: the restart triggered by a configuration change, and the counter's own wrap at the end of a period. The bench changes the ratio while the divided clock is low, partway through a period. It expects the very next edge to start a fresh high phase of the new length rather than finish the old period. It also toggles only the reserved bit during a high phase and expects the running high and low counts to stay unchanged.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CFG_W    = 8;
  localparam int RATIO_W  = 5;
  localparam int EN_BIT   = 0;
  localparam int CODE_LSB = 1;
  localparam int INV_BIT  = CODE_LSB + RATIO_W;

  typedef logic [RATIO_W-1:0] code_t;

  typedef struct packed {
    logic  en;
    code_t code;
  } key_t;
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output logic             en_o,
  output logic             inv_o,
  output code_t            code_o,
  output logic             active_o,
  output code_t            hi_last_o
);
  logic unused_rsvd;

  assign en_o        = cfg_i[EN_BIT];
  assign inv_o       = cfg_i[INV_BIT];
  assign code_o      = cfg_i[CODE_LSB +: RATIO_W];
  assign unused_rsvd = cfg_i[CFG_W-1];

  // divider acts only when enabled with a ratio above one
  assign active_o  = en_o && (code_o != '0);
  // last counter value of the high phase: ceil(N/2)-1 == code>>1
  assign hi_last_o = code_o >> 1;

  always_comb begin
    if (active_o) a_hi_range_r4 : assert (hi_last_o < code_o);
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  code_t code_i,
  input  logic  active_i,
  input  code_t hi_last_i,
  output logic  div_o
);
  code_t cnt_q, cnt_nxt;
  key_t  key_q, key_now;
  logic  changed;

  assign key_now = '{en: en_i, code: code_i};
  assign changed = (key_now != key_q);

  always_comb begin
    if (changed || (cnt_q >= code_i)) cnt_nxt = '0;
    else                              cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_o <= 1'b0;
      key_q <= '0;
    end else begin
      key_q <= key_now;
      if (!active_i) begin
        cnt_q <= '0;
        div_o <= 1'b0;
      end else begin
        cnt_q <= cnt_nxt;
        div_o <= (cnt_nxt <= hi_last_i);
      end
    end
  end

  p_cnt_bound_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !changed) |-> (cnt_q <= code_i));

  p_wrap_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !changed && cnt_q == code_i) |=> (cnt_q == '0 && div_o));

  p_restart_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && changed) |=> (cnt_q == '0 && div_o));

  p_fall_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !changed && cnt_q == hi_last_i) |=> !div_o);

  p_rise_at_zero_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out (
  input  logic clk_i,
  input  logic div_i,
  input  logic active_i,
  input  logic inv_i,
  output logic clk_o
);
  logic pre_inv;

  assign pre_inv = active_i ? div_i : clk_i;
  assign clk_o   = pre_inv ^ inv_i;
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             clk_o
);
  logic  en, inv, active, div;
  code_t code, hi_last;

  clkdiv_decode u_decode (
    .cfg_i     (cfg_i),
    .en_o      (en),
    .inv_o     (inv),
    .code_o    (code),
    .active_o  (active),
    .hi_last_o (hi_last)
  );

  clkdiv_counter u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .code_i    (code),
    .active_i  (active),
    .hi_last_i (hi_last),
    .div_o     (div)
  );

  clkdiv_out u_out (
    .clk_i    (clk_i),
    .div_i    (div),
    .active_i (active),
    .inv_i    (inv),
    .clk_o    (clk_o)
  );

  p_reset_low_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active) |=> ($past(active) || !div));
endmodule

// File: tb/clkdiv_top_tb.sv
module clkdiv_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       clk_out;
  logic       inv_e = 1'b0;
  int         n_checks = 0;
  int         n_errors = 0;

  clkdiv_top u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cfg_i  (cfg),
    .clk_o  (clk_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit en, input int code, input bit inv);
    return {1'b0, inv, code[4:0], en};
  endfunction

  // pre-inversion value sampled in the high half of the input cycle
  task automatic get(output bit v);
    @(posedge clk); #2;
    v = clk_out ^ inv_e;
  endtask

  task automatic test_reset_r9();
    rst_n = 1'b0;
    cfg = mk(1, 3, 0); inv_e = 0;
    #(CLK_PERIOD*2 + 2);
    check("R9 reset low", clk_out, 0);
    cfg = mk(1, 3, 1);
    #(CLK_PERIOD);
    check("R9 reset inv", clk_out, 1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_ratio(input int code, input bit inv);
    bit v, p;
    int hi, lo, guard, n;
    n = code + 1;
    @(negedge clk); cfg = mk(0, code, inv); inv_e = inv;
    @(negedge clk); cfg = mk(1, code, inv);
    if (code == 0) begin
      @(posedge clk); #2;
      check("R5 bypass high", clk_out, 1 ^ inv);
      #(CLK_PERIOD/2);
      check("R5 bypass low", clk_out, 0 ^ inv);
      return;
    end
    @(posedge clk); #2;
    check("R7 R8 first phase", clk_out, 1 ^ inv);
    repeat (70) @(posedge clk);
    guard = 0;
    get(p);
    do begin get(v); guard++; if (p == 0 && v == 1) break; p = v; end while (guard < 100);
    hi = 1;
    get(v);
    while (v == 1 && hi < 100) begin hi++; get(v); end
    lo = 0;
    while (v == 0 && lo < 100) begin lo++; get(v); end
    check("R2 period", hi + lo, n);
    if (n % 2 == 0) check("R3 even high", hi, n / 2);
    else            check("R4 odd high", hi, (n + 1) / 2);
  endtask

  task automatic test_disabled_r6(input bit inv);
    @(negedge clk); cfg = mk(0, 7, inv);
    @(posedge clk); #2;
    check("R6 disabled high", clk_out, 1 ^ inv);
    #(CLK_PERIOD/2);
    check("R6 disabled low", clk_out, 0 ^ inv);
  endtask

  task automatic test_restart_r8();
    bit v;
    int guard;
    inv_e = 0;
    @(negedge clk); cfg = mk(1, 5, 0);
    repeat (20) @(posedge clk);
    guard = 0;
    do begin get(v); guard++; end while (v != 0 && guard < 50);
    @(negedge clk); cfg = mk(1, 3, 0);
    get(v); check("R8 restart c1", v, 1);
    get(v); check("R8 restart c2", v, 1);
    get(v); check("R8 restart c3", v, 0);
    get(v); check("R8 restart c4", v, 0);
    get(v); check("R8 restart c5", v, 1);
  endtask

  task automatic test_rsvd_r10();
    bit v, p;
    int guard;
    inv_e = 0;
    @(negedge clk); cfg = mk(1, 5, 0);
    repeat (20) @(posedge clk);
    guard = 0;
    get(p);
    do begin get(v); guard++; if (p == 0 && v == 1) break; p = v; end while (guard < 50);
    @(negedge clk); cfg = mk(1, 5, 0) | 8'h80;
    get(v); check("R10 rsvd h2", v, 1);
    get(v); check("R10 rsvd h3", v, 1);
    get(v); check("R10 rsvd l1", v, 0);
    get(v); check("R10 rsvd l2", v, 0);
    get(v); check("R10 rsvd l3", v, 0);
    get(v); check("R10 rsvd next", v, 1);
  endtask

  initial begin
    test_reset_r9();
    for (int c = 0; c < 32; c++) begin
      test_ratio(c, 0);   // R1 R2 R3 R4 R5
      test_ratio(c, 1);   // R7
    end
    test_disabled_r6(0);
    test_disabled_r6(1);
    test_restart_r8();
    test_rsvd_r10();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule